// File: doc/BRIEF.md
# Frequency Offset to Counter Correction Converter

This unit turns a signed frequency error, given in parts per billion, into the two values a time-of-day counter needs to steer its rate. The first is a corrected per-tick increment, used on correction ticks in place of the nominal increment. The second is a period, the number of ticks between correction ticks. A clock servo supplies the error and the nominal increment, then pulses `start_i`. The unit makes one pulse on `done_o` when the new pair is ready. Writing the pair into the counter is left to the surrounding logic.

The unit does not compute the ratio directly. It tries adjustment steps of 1, 2, 3 and upward, one per clock, against a threshold. The threshold starts at one billion and grows by one billion after each failed try. The first step that passes sets the correction. A 64-bit restoring divider then finds the period. If no step up to the nominal increment passes, the unit falls back to the strongest correction it can apply.

Top module: `ppb_corr_calc`

## Requirements
- R1: After reset, `done_o` is 0 and both `corr_inc_o` and `period_o` are 0.
- R2: A start with `ppb_i` equal to 0 makes `done_o` high in the cycle after the start. It leaves `corr_inc_o` and `period_o` unchanged.
- R3: `ppb_i` is a 32-bit two's-complement value, and its magnitude is used for the search. A negative value gives `corr_inc_o` = nominal − step. A positive value gives `corr_inc_o` = nominal + step.
- R4: The step is the smallest integer k with 1 ≤ k ≤ `inc_nom_i` for which k·10^9 ≥ |`ppb_i`|·`inc_nom_i`.
- R5: When a step k is found, `period_o` = floor(k·10^9 / (|`ppb_i`|·`inc_nom_i`)).
- R6: When no step qualifies, the step equals `inc_nom_i` and `period_o` is 1. This includes the case `inc_nom_i` = 0. `corr_inc_o` then never exceeds twice the nominal increment.
- R7: `done_o` is high for exactly one clock per accepted start. `corr_inc_o` and `period_o` change only on the edge that raises `done_o`.
- R8: A start that arrives while a calculation is running is ignored. It produces no extra `done_o` and does not alter the result that is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a calculation |
| ppb_i | input | 32 | Signed frequency offset in parts per billion |
| inc_nom_i | input | 8 | Nominal counter increment per tick |
| done_o | output | 1 | One-cycle strobe: results are ready |
| corr_inc_o | output | 9 | Increment to apply on correction ticks |
| period_o | output | 64 | Ticks between correction ticks |

## Verification
The checks assume that `ppb_i` and `inc_nom_i` are sampled only in the cycle `start_i` is high while the unit is idle. They also assume the product |`ppb_i`|·`inc_nom_i` stays below 2^40, so that the divider's quotient check cannot overflow 64 bits. The scoreboard driver holds each operand pair for exactly one clock beside the start pulse. It deliberately raises a second start, with different operands, in the middle of a running divide. A result it predicts for the first request and no result for the second shows that the second start was dropped. Operands are chosen to hit the first step, a later step, the fallback, the most negative offset and a zero nominal increment.

// File: rtl/ppb_corr_pkg.sv
package ppb_corr_pkg;

    localparam logic [63:0] ONE_BILLION = 64'd1_000_000_000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_DIVIDE
    } ctrl_state_e;

endpackage

// File: rtl/ppb_step_search.sv
// Tries adjustment steps 1..limit, one per clock, against a threshold that
// grows by one billion per failed try.
module ppb_step_search #(
    parameter int INC_W = 8,
    parameter int DIV_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [DIV_W-1:0] rhs_i,
    input  logic [INC_W-1:0] limit_i,
    output logic             hit_o,
    output logic             miss_o,
    output logic [INC_W-1:0] step_o,
    output logic [DIV_W-1:0] lhs_o
);
    import ppb_corr_pkg::*;

    localparam logic [DIV_W-1:0] STEP_LHS = DIV_W'(ONE_BILLION);

    typedef struct packed {
        logic             active;
        logic [INC_W-1:0] cand;
        logic [DIV_W-1:0] lhs;
        logic             hit;
        logic             miss;
    } srch_t;

    srch_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.hit  = 1'b0;
        s_d.miss = 1'b0;
        if (go_i) begin
            s_d.cand   = INC_W'(1);
            s_d.lhs    = STEP_LHS;
            s_d.active = (limit_i != '0);
            s_d.miss   = (limit_i == '0);
        end else if (s_q.active) begin
            if (s_q.lhs >= rhs_i) begin
                s_d.hit    = 1'b1;
                s_d.active = 1'b0;
            end else if (s_q.cand >= limit_i) begin
                s_d.miss   = 1'b1;
                s_d.active = 1'b0;
            end else begin
                s_d.cand = s_q.cand + INC_W'(1);
                s_d.lhs  = s_q.lhs + STEP_LHS;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit_o  = s_q.hit;
    assign miss_o = s_q.miss;
    assign step_o = s_q.cand;
    assign lhs_o  = s_q.lhs;
endmodule

// File: rtl/ppb_restoring_div.sv
// Unsigned restoring divider, one quotient bit per clock.
module ppb_restoring_div #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         fin_o,
    output logic [W-1:0] quo_o
);
    localparam int CNT_W = $clog2(W) + 1;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rem;
        logic [W-1:0]     quo;
        logic             fin;
    } div_t;

    div_t v_d, v_q;
    logic [W:0] trial;

    always_comb begin
        v_d     = v_q;
        v_d.fin = 1'b0;
        trial   = {v_q.rem, v_q.quo[W-1]};
        if (go_i) begin
            v_d.active = 1'b1;
            v_d.cnt    = CNT_W'(W);
            v_d.rem    = '0;
            v_d.quo    = dividend_i;
        end else if (v_q.active) begin
            if (trial >= {1'b0, divisor_i}) begin
                v_d.rem = W'(trial - {1'b0, divisor_i});
                v_d.quo = {v_q.quo[W-2:0], 1'b1};
            end else begin
                v_d.rem = trial[W-1:0];
                v_d.quo = {v_q.quo[W-2:0], 1'b0};
            end
            v_d.cnt = v_q.cnt - CNT_W'(1);
            if (v_q.cnt == CNT_W'(1)) begin
                v_d.active = 1'b0;
                v_d.fin    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign fin_o = v_q.fin;
    assign quo_o = v_q.quo;
endmodule

// File: rtl/ppb_corr_calc.sv
module ppb_corr_calc #(
    parameter int OFS_W = 32,
    parameter int INC_W = 8,
    parameter int DIV_W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic signed [OFS_W-1:0] ppb_i,
    input  logic [INC_W-1:0]        inc_nom_i,
    output logic                    done_o,
    output logic [INC_W:0]          corr_inc_o,
    output logic [DIV_W-1:0]        period_o
);
    import ppb_corr_pkg::*;

    typedef struct packed {
        ctrl_state_e      st;
        logic             neg;
        logic [INC_W-1:0] inc;
        logic [DIV_W-1:0] rhs;
        logic [INC_W-1:0] step;
        logic             srch_go;
        logic             div_go;
        logic             done;
        logic [INC_W:0]   corr;
        logic [DIV_W-1:0] period;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic [OFS_W-1:0] mag;
    logic             srch_hit, srch_miss, div_fin;
    logic [INC_W-1:0] srch_step;
    logic [DIV_W-1:0] srch_lhs, div_quo;
    logic             busy;

    function automatic logic [INC_W:0] apply_step(input logic neg, input logic [INC_W-1:0] nom,
                                                  input logic [INC_W-1:0] stp);
        return neg ? ({1'b0, nom} - {1'b0, stp}) : ({1'b0, nom} + {1'b0, stp});
    endfunction

    assign mag  = ppb_i[OFS_W-1] ? (~ppb_i + OFS_W'(1)) : ppb_i;
    assign busy = (c_q.st != ST_IDLE);

    always_comb begin
        c_d         = c_q;
        c_d.srch_go = 1'b0;
        c_d.div_go  = 1'b0;
        c_d.done    = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (ppb_i == '0) begin
                        c_d.done = 1'b1;
                    end else begin
                        c_d.neg     = ppb_i[OFS_W-1];
                        c_d.inc     = inc_nom_i;
                        c_d.rhs     = DIV_W'(mag) * DIV_W'(inc_nom_i);
                        c_d.srch_go = 1'b1;
                        c_d.st      = ST_SEARCH;
                    end
                end
            end
            ST_SEARCH: begin
                if (srch_hit) begin
                    c_d.step   = srch_step;
                    c_d.div_go = 1'b1;
                    c_d.st     = ST_DIVIDE;
                end else if (srch_miss) begin
                    c_d.step   = c_q.inc;
                    c_d.corr   = apply_step(c_q.neg, c_q.inc, c_q.inc);
                    c_d.period = DIV_W'(1);
                    c_d.done   = 1'b1;
                    c_d.st     = ST_IDLE;
                end
            end
            ST_DIVIDE: begin
                if (div_fin) begin
                    c_d.corr   = apply_step(c_q.neg, c_q.inc, c_q.step);
                    c_d.period = div_quo;
                    c_d.done   = 1'b1;
                    c_d.st     = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    ppb_step_search #(.INC_W(INC_W), .DIV_W(DIV_W)) u_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (c_q.srch_go),
        .rhs_i   (c_q.rhs),
        .limit_i (c_q.inc),
        .hit_o   (srch_hit),
        .miss_o  (srch_miss),
        .step_o  (srch_step),
        .lhs_o   (srch_lhs)
    );

    ppb_restoring_div #(.W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (c_q.div_go),
        .dividend_i (srch_lhs),
        .divisor_i  (c_q.rhs),
        .fin_o      (div_fin),
        .quo_o      (div_quo)
    );

    assign done_o     = c_q.done;
    assign corr_inc_o = c_q.corr;
    assign period_o   = c_q.period;
endmodule

// File: rtl/ppb_corr_calc_chk.sv
module ppb_corr_calc_chk #(
    parameter int INC_W = 8,
    parameter int DIV_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy,
    input logic             done_o,
    input logic [INC_W:0]   corr_inc_o,
    input logic [DIV_W-1:0] period_o,
    input logic [INC_W-1:0] inc_lat,
    input logic             srch_hit,
    input logic             srch_miss,
    input logic             div_fin,
    input logic [DIV_W-1:0] div_quo,
    input logic [DIV_W-1:0] div_dvd,
    input logic [DIV_W-1:0] div_dvs
);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(corr_inc_o) && $stable(period_o)));

    a_r6_corr_range: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (corr_inc_o <= ({1'b0, inc_lat} << 1)));

    a_r4_search_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(srch_hit && srch_miss));

    a_r5_quotient: assert property (@(posedge clk) disable iff (!rst_n)
        div_fin |-> ((div_quo * div_dvs <= div_dvd) &&
                     (div_dvd - div_quo * div_dvs < div_dvs)));

    a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> $stable(inc_lat));
endmodule

bind ppb_corr_calc ppb_corr_calc_chk #(.INC_W(INC_W), .DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy       (busy),
    .done_o     (done_o),
    .corr_inc_o (corr_inc_o),
    .period_o   (period_o),
    .inc_lat    (c_q.inc),
    .srch_hit   (srch_hit),
    .srch_miss  (srch_miss),
    .div_fin    (div_fin),
    .div_quo    (div_quo),
    .div_dvd    (srch_lhs),
    .div_dvs    (c_q.rhs)
);

// File: tb/ppb_corr_calc_test.sv
module ppb_corr_calc_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic signed [31:0] ppb_i = '0;
    logic [7:0]         inc_nom_i = '0;
    logic               done_o;
    logic [8:0]         corr_inc_o;
    logic [63:0]        period_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    typedef struct {
        logic [8:0]  corr;
        logic [63:0] per;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    logic [8:0]  last_corr = '0;
    logic [63:0] last_per  = '0;
    bit          prev_done = 0;

    always #5 clk = ~clk;

    ppb_corr_calc uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ppb_i      (ppb_i),
        .inc_nom_i  (inc_nom_i),
        .done_o     (done_o),
        .corr_inc_o (corr_inc_o),
        .period_o   (period_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_test();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Expected result from the requirements (R3..R6)
    task automatic model(input logic signed [31:0] p, input logic [7:0] nom,
                         output logic [8:0] corr, output logic [63:0] per, output bit upd);
        logic [63:0] mag, rhs, lhs;
        logic [7:0]  step;
        bit          found;
        upd   = (p != 0);
        corr  = last_corr;
        per   = last_per;
        if (!upd) return;
        mag   = (p < 0) ? 64'(-64'(p)) : 64'(p);
        rhs   = mag * 64'(nom);
        lhs   = 64'd1_000_000_000;
        found = 0;
        step  = '0;
        for (int i = 1; i <= int'(nom); i++) begin
            if (!found) begin
                if (lhs >= rhs) begin
                    step  = 8'(i);
                    per   = lhs / rhs;
                    found = 1;
                end else begin
                    lhs += 64'd1_000_000_000;
                end
            end
        end
        if (!found) begin
            step = nom;
            per  = 64'd1;
        end
        corr = (p < 0) ? ({1'b0, nom} - {1'b0, step}) : ({1'b0, nom} + {1'b0, step});
    endtask

    task automatic pulse_start(input logic signed [31:0] p, input logic [7:0] nom);
        @(negedge clk);
        ppb_i     = p;
        inc_nom_i = nom;
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        ppb_i     = '0;
        inc_nom_i = '0;
    endtask

    task automatic wait_drain();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_case(input logic signed [31:0] p, input logic [7:0] nom, input string req);
        exp_t        e;
        logic [8:0]  c;
        logic [63:0] pr;
        bit          upd;
        model(p, nom, c, pr, upd);
        last_corr = c;
        last_per  = pr;
        e.corr = c;
        e.per  = pr;
        e.req  = req;
        sb_q.push_back(e);
        pulse_start(p, nom);
        if (!upd) check(done_o === 1'b1, "R2 done one cycle after zero start", 64'(done_o), 64'd1);
        wait_drain();
    endtask

    // Monitor: pops the scoreboard on every done strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                check(!prev_done, "R7 done lasts one clock", 64'(prev_done), 64'd0);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8 unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(corr_inc_o === e.corr, {e.req, " corr_inc"}, 64'(corr_inc_o), 64'(e.corr));
                    check(period_o === e.per, {e.req, " period"}, period_o, e.per);
                end
            end
            prev_done = done_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        finish_test();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done_o === 1'b0, "R1 done after reset", 64'(done_o), 64'd0);
        check(corr_inc_o === '0, "R1 corr_inc after reset", 64'(corr_inc_o), 64'd0);
        check(period_o === '0, "R1 period after reset", period_o, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_case(32'sd100, 8'd8, "R4 R5 first step");           // step 1, period 1250000, corr 9
        run_case(-32'sd1000, 8'd20, "R3 R5 slow down");          // step 1, corr 19, period 50000
        run_case(32'sd0, 8'd20, "R2 zero offset holds");
        run_case(32'sd200_000_000, 8'd8, "R4 later step");       // step 2, period 1, corr 10
        run_case(32'sd999_999_999, 8'd3, "R4 last step");        // step 3, period 1, corr 6
        run_case(32'sd2_000_000_000, 8'd4, "R6 fallback fast");  // corr 8, period 1
        run_case(-32'sd2_000_000_000, 8'd4, "R6 fallback slow"); // corr 0, period 1
        run_case(-32'sd2147483647 - 32'sd1, 8'd255, "R3 R6 most negative");
        run_case(32'sd5, 8'd0, "R6 zero nominal");               // corr 0, period 1
        run_case(32'sd7, 8'd10, "R5 large quotient");
        run_case(-32'sd12345, 8'd40, "R3 R5 mid offset");
        run_case(32'sd0, 8'd1, "R2 zero after update");

        // R8: a second start during the divide must be dropped
        begin
            exp_t        e;
            logic [8:0]  c;
            logic [63:0] pr;
            bit          upd;
            model(32'sd250, 8'd16, c, pr, upd);
            last_corr = c;
            last_per  = pr;
            e.corr = c;
            e.per  = pr;
            e.req  = "R8 start while busy ignored";
            sb_q.push_back(e);
            pulse_start(32'sd250, 8'd16);
            repeat (10) @(negedge clk);
            pulse_start(-32'sd900_000_000, 8'd2);
            wait_drain();
            repeat (100) @(negedge clk);
            check(sb_q.size() == 0, "R8 no pending results", 64'(sb_q.size()), 64'd0);
            check(corr_inc_o === c, "R8 result kept", 64'(corr_inc_o), 64'(c));
        end

        run_case(32'sd64, 8'd50, "R4 R5 after busy start");
        finish_test();
    end
endmodule